// File: doc/BRIEF.md
# Intra Residual Coefficient Quantizer / Dequantizer

This block takes one signed transform coefficient from a 4x4 residual block of an intra video coder and gives back both its quantized level and the coefficient rebuilt from that level, as the decoder would see it. Each input carries a quantization parameter (QP), a flag that marks it as a DC coefficient (the output of the second-stage DC transform) or an AC coefficient, and its position inside the 4x4 block. A valid strobe qualifies every input. One coefficient can be accepted on every clock.

The forward path scales the magnitude by a multiplier chosen from QP and position, adds a rounding offset, and shifts right by an amount that grows with QP. The sign is added back at the end. DC coefficients get twice the rounding offset and one more bit of right shift. The inverse path scales the level by a second table constant. AC coefficients are then shifted left by QP/6. DC coefficients are shifted left for QP of 12 and above, and below 12 they take a rounded arithmetic right shift. Both tables are held inside the block. The only wide multiplier sits in the forward path. Results leave through a three-register pipeline.

Top module: `intra_qdq`

## Requirements
- R1: QP values above 51 are treated as 51. With qpDiv = floor(QP/6) and qpRem = QP mod 6, the forward shift is qbits = 15 + qpDiv.
- R2: For an AC input W (isDcIn = 0), |level| = (|W|·MF + f) >> qbits, with f = floor(2^qbits / 3).
- R3: For a DC input Y (isDcIn = 1), |level| = (|Y|·MF + 2f) >> (qbits + 1).
- R4: MF and V are picked by qpRem and by a position class. posIn[3:2] is the row and posIn[1:0] is the column. Class "even" means row and column are both even, class "odd" means both are odd, and class "mixed" covers every other position. MF rows for qpRem 0..5: even {13107,11916,10082,9362,8192,7282}, odd {5243,4660,4194,3647,3355,2893}, mixed {8066,7490,6554,5825,5243,4559}. V rows: even {10,11,13,14,16,18}, odd {16,18,20,23,25,29}, mixed {13,14,16,18,20,23}.
- R5: The level takes the sign of the input. A zero input gives a level of zero and a rebuilt value of zero.
- R6: For AC, the rebuilt value is level·V·2^qpDiv.
- R7: For DC with QP ≥ 12, the rebuilt value is (level·V) << (qpDiv − 2).
- R8: For DC with QP < 12, the rebuilt value is (level·V + 2^(1−qpDiv)) >> (2 − qpDiv), using an arithmetic (flooring) shift.
- R9: A valid input in cycle t gives outValid = 1 in cycle t+3, carrying the results for that input. In any cycle where no valid result is due, outValid is 0 and levelOut and reconOut keep their last values.
- R10: After reset, outValid, levelOut and reconOut are all 0.
- R11: Inputs on consecutive cycles give outputs on consecutive cycles, each result matching its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies the input fields |
| coefIn | input | 16 | Signed coefficient to quantize |
| qpIn | input | 6 | Quantization parameter; values above 51 are clamped |
| isDcIn | input | 1 | 1 marks a DC coefficient, 0 an AC coefficient |
| posIn | input | 4 | Position in the block: [3:2] is the row, [1:0] is the column |
| outValid | output | 1 | Results for the input from three cycles earlier |
| levelOut | output | 18 | Signed quantized level |
| reconOut | output | 32 | Signed rebuilt coefficient |

## Verification
The level and the rebuilt coefficient both appear three clock cycles after their input, because the input passes three registers: the product, the level, and the output. The bench drives inputs on falling edges and keeps a three-deep history of expected results. On each falling edge it compares the outputs with the oldest entry before it drives the next input. Idle slots are placed in the stream, and on those slots the bench checks that outValid is low and that both outputs still hold their previous values. The sweep runs over every QP from 0 to 55, all 16 positions, both DC and AC, and a set of coefficients that includes zero, ±1 and both extremes of the 16-bit range.

// File: rtl/qdq_pkg.sv
package qdq_pkg;

  localparam int QP_LIMIT  = 51;
  localparam int QBITS_MIN = 15;
  localparam int PIPE_LAT  = 3;
  localparam int MF_W      = 14;
  localparam int V_W       = 5;

  typedef enum logic [1:0] {
    CLS_EVEN = 2'd0,
    CLS_ODD  = 2'd1,
    CLS_MIX  = 2'd2
  } posCls_e;

  // Register-load strobes from control to datapath, one per pipeline stage.
  typedef struct packed {
    logic ldProd;
    logic ldLevel;
    logic ldOut;
  } qdqStrobe_t;

  function automatic posCls_e posClass(input logic [3:0] pos);
    if (!pos[2] && !pos[0])     return CLS_EVEN;
    else if (pos[2] && pos[0])  return CLS_ODD;
    else                        return CLS_MIX;
  endfunction

  function automatic logic [MF_W-1:0] mfLookup(input logic [2:0] rem, input posCls_e cls);
    logic [MF_W-1:0] r;
    case (cls)
      CLS_EVEN: case (rem)
        3'd0: r = 14'd13107; 3'd1: r = 14'd11916; 3'd2: r = 14'd10082;
        3'd3: r = 14'd9362;  3'd4: r = 14'd8192;  default: r = 14'd7282;
      endcase
      CLS_ODD: case (rem)
        3'd0: r = 14'd5243;  3'd1: r = 14'd4660;  3'd2: r = 14'd4194;
        3'd3: r = 14'd3647;  3'd4: r = 14'd3355;  default: r = 14'd2893;
      endcase
      default: case (rem)
        3'd0: r = 14'd8066;  3'd1: r = 14'd7490;  3'd2: r = 14'd6554;
        3'd3: r = 14'd5825;  3'd4: r = 14'd5243;  default: r = 14'd4559;
      endcase
    endcase
    return r;
  endfunction

  function automatic logic [V_W-1:0] vLookup(input logic [2:0] rem, input posCls_e cls);
    logic [V_W-1:0] r;
    case (cls)
      CLS_EVEN: case (rem)
        3'd0: r = 5'd10; 3'd1: r = 5'd11; 3'd2: r = 5'd13;
        3'd3: r = 5'd14; 3'd4: r = 5'd16; default: r = 5'd18;
      endcase
      CLS_ODD: case (rem)
        3'd0: r = 5'd16; 3'd1: r = 5'd18; 3'd2: r = 5'd20;
        3'd3: r = 5'd23; 3'd4: r = 5'd25; default: r = 5'd29;
      endcase
      default: case (rem)
        3'd0: r = 5'd13; 3'd1: r = 5'd14; 3'd2: r = 5'd16;
        3'd3: r = 5'd18; 3'd4: r = 5'd20; default: r = 5'd23;
      endcase
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qdq_ctrl.sv
module qdq_ctrl
  import qdq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output qdqStrobe_t stb,
  output logic       outValid
);

  logic [PIPE_LAT-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[PIPE_LAT-2:0], inValid};
  end

  always_comb begin
    stb.ldProd  = inValid;
    stb.ldLevel = vPipe[0];
    stb.ldOut   = vPipe[1];
  end

  assign outValid = vPipe[PIPE_LAT-1];

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

endmodule

// File: rtl/qdq_datapath.sv
module qdq_datapath
  import qdq_pkg::*;
#(
  parameter int CW = 16,
  parameter int QW = 6,
  parameter int PW = CW + 16,
  parameter int LW = PW - QBITS_MIN + 1,
  parameter int RW = CW + 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qdqStrobe_t           stb,
  input  logic signed [CW-1:0] coefIn,
  input  logic [QW-1:0]        qpIn,
  input  logic                 isDcIn,
  input  logic [3:0]           posIn,
  output logic signed [LW-1:0] levelOut,
  output logic signed [RW-1:0] reconOut
);

  localparam int DIV_W = 4;
  localparam logic signed [RW-1:0] ONE_S = RW'(1);
  localparam logic signed [RW-1:0] TWO_S = RW'(2);

  // ---------------- stage 0: QP split, table pick, magnitude, multiply
  logic [QW-1:0]       qpClamp;
  logic [11:0]         qpScaled;
  logic [DIV_W-1:0]    qpDiv;
  logic [7:0]          qpRemWide;
  logic [2:0]          qpRem;
  posCls_e             cls;
  logic [MF_W-1:0]     mfSel;
  logic [V_W-1:0]      vSel;
  logic                inSgn;
  logic [CW-1:0]       absW;
  logic [PW-1:0]       prodW;

  always_comb begin
    qpClamp   = (int'(qpIn) > QP_LIMIT) ? QW'(QP_LIMIT) : qpIn;
    qpScaled  = 12'(qpClamp) * 12'd43;          // floor(q/6) == (q*43)>>8 for q<=51
    qpDiv     = qpScaled[11:8];
    qpRemWide = 8'(qpClamp) - 8'(qpDiv) * 8'd6;
    qpRem     = qpRemWide[2:0];
    cls       = posClass(posIn);
    mfSel     = mfLookup(qpRem, cls);
    vSel      = vLookup(qpRem, cls);
    inSgn     = coefIn[CW-1];
    absW      = inSgn ? CW'(-coefIn) : coefIn;
    prodW     = PW'(absW) * PW'(mfSel);
  end

  logic [PW-1:0]    s1Prod;
  logic             s1Sgn;
  logic             s1Dc;
  logic [DIV_W-1:0] s1Div;
  logic [V_W-1:0]   s1V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Prod <= '0; s1Sgn <= 1'b0; s1Dc <= 1'b0; s1Div <= '0; s1V <= '0;
    end else if (stb.ldProd) begin
      s1Prod <= prodW; s1Sgn <= inSgn; s1Dc <= isDcIn; s1Div <= qpDiv; s1V <= vSel;
    end
  end

  // R1
  qp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldProd |=> (s1Div <= DIV_W'(QP_LIMIT / 6)));

  // ---------------- stage 1: rounding offset, shift, sign
  logic [5:0]           qBits;
  logic [5:0]           shAmt;
  logic [PW-1:0]        fVal;
  logic [PW-1:0]        rndVal;
  logic [PW-1:0]        sumVal;
  logic [PW-1:0]        magVal;
  logic [LW-1:0]        magT;
  logic signed [LW-1:0] levNext;

  always_comb begin
    qBits = 6'(QBITS_MIN) + 6'(s1Div);
    shAmt = qBits + 6'(s1Dc);
    // floor(2^qBits/3): alternating ones from bit qBits-2 downward
    fVal = '0;
    for (int i = 0; i < PW; i++) begin
      if ((i + 2 <= int'(qBits)) && (((int'(qBits) - i) % 2) == 0)) fVal[i] = 1'b1;
    end
    rndVal  = s1Dc ? (fVal << 1) : fVal;
    sumVal  = s1Prod + rndVal;
    magVal  = sumVal >> shAmt;
    magT    = magVal[LW-1:0];
    levNext = s1Sgn ? -$signed(magT) : $signed(magT);
  end

  logic signed [LW-1:0] s2Lev;
  logic                 s2Dc;
  logic [DIV_W-1:0]     s2Div;
  logic [V_W-1:0]       s2V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Lev <= '0; s2Dc <= 1'b0; s2Div <= '0; s2V <= '0;
    end else if (stb.ldLevel) begin
      s2Lev <= levNext; s2Dc <= s1Dc; s2Div <= s1Div; s2V <= s1V;
    end
  end

  // R5
  level_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldLevel |=> ((s2Lev == '0) || (s2Lev[LW-1] == $past(s1Sgn))));

  // ---------------- stage 2: inverse scaling
  logic signed [RW-1:0] lvExt;
  logic signed [RW-1:0] vExt;
  logic signed [RW-1:0] scaled;
  logic signed [RW-1:0] reconNext;

  always_comb begin
    lvExt  = RW'(s2Lev);
    vExt   = $signed(RW'(s2V));
    scaled = lvExt * vExt;
    if (!s2Dc)                  reconNext = scaled <<< s2Div;
    else if (s2Div >= DIV_W'(2)) reconNext = scaled <<< (s2Div - DIV_W'(2));
    else if (s2Div == DIV_W'(1)) reconNext = (scaled + ONE_S) >>> 1;
    else                        reconNext = (scaled + TWO_S) >>> 2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelOut <= '0; reconOut <= '0;
    end else if (stb.ldOut) begin
      levelOut <= s2Lev; reconOut <= reconNext;
    end
  end

  // R5
  zero_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldOut |=> ((levelOut == '0) == (reconOut == '0)));

  // R6
  recon_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldOut |=> ((levelOut == '0) || (reconOut[RW-1] == levelOut[LW-1])));

endmodule

// File: rtl/intra_qdq.sv
module intra_qdq
  import qdq_pkg::*;
#(
  parameter int CW = 16,
  parameter int QW = 6,
  localparam int LW = CW + 2,
  localparam int RW = CW + 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [CW-1:0] coefIn,
  input  logic [QW-1:0]        qpIn,
  input  logic                 isDcIn,
  input  logic [3:0]           posIn,
  output logic                 outValid,
  output logic signed [LW-1:0] levelOut,
  output logic signed [RW-1:0] reconOut
);

  qdqStrobe_t stb;

  qdq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  qdq_datapath #(
    .CW (CW),
    .QW (QW),
    .PW (CW + 16),
    .LW (LW),
    .RW (RW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .coefIn   (coefIn),
    .qpIn     (qpIn),
    .isDcIn   (isDcIn),
    .posIn    (posIn),
    .levelOut (levelOut),
    .reconOut (reconOut)
  );

endmodule

// File: tb/intra_qdq_tb.sv
module intra_qdq_tb;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic signed [15:0] coefIn = '0;
  logic [5:0]         qpIn = '0;
  logic               isDcIn = 1'b0;
  logic [3:0]         posIn = '0;
  logic               outValid;
  logic signed [17:0] levelOut;
  logic signed [31:0] reconOut;

  always #5 clk = ~clk;

  intra_qdq u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .coefIn(coefIn), .qpIn(qpIn),
    .isDcIn(isDcIn), .posIn(posIn), .outValid(outValid), .levelOut(levelOut),
    .reconOut(reconOut)
  );

  int    nChk = 0;
  int    nBad = 0;
  bit    done = 1'b0;
  bit    hv[3];
  bit    hBurst[3];
  longint hl[3];
  longint hr[3];
  string htL[3];
  string htR[3];
  longint heldL = 0;
  longint heldR = 0;
  bit    prevV = 1'b0;

  function automatic longint mfOf(int rem, int cls);
    int t0[6] = '{13107, 11916, 10082, 9362, 8192, 7282};
    int t1[6] = '{5243, 4660, 4194, 3647, 3355, 2893};
    int t2[6] = '{8066, 7490, 6554, 5825, 5243, 4559};
    return (cls == 0) ? t0[rem] : (cls == 1) ? t1[rem] : t2[rem];
  endfunction

  function automatic longint vOf(int rem, int cls);
    int t0[6] = '{10, 11, 13, 14, 16, 18};
    int t1[6] = '{16, 18, 20, 23, 25, 29};
    int t2[6] = '{13, 14, 16, 18, 20, 23};
    return (cls == 0) ? t0[rem] : (cls == 1) ? t1[rem] : t2[rem];
  endfunction

  // Expected results built from R1..R8
  task automatic model(input int coef, input int qp, input bit dc, input int pos,
                       output longint lev, output longint rec);
    int qpc = (qp > 51) ? 51 : qp;
    int d = qpc / 6;
    int m = qpc % 6;
    int row = pos / 4;
    int col = pos % 4;
    int cls = ((row % 2 == 0) && (col % 2 == 0)) ? 0 :
              ((row % 2 == 1) && (col % 2 == 1)) ? 1 : 2;
    int qb = 15 + d;
    longint f = (64'sd1 <<< qb) / 3;
    longint aw = (coef < 0) ? -coef : coef;
    longint mag;
    longint p;
    if (dc) mag = (aw * mfOf(m, cls) + 2 * f) >>> (qb + 1);
    else    mag = (aw * mfOf(m, cls) + f) >>> qb;
    lev = (coef < 0) ? -mag : mag;
    p = lev * vOf(m, cls);
    if (!dc)        rec = p * (64'sd1 <<< d);
    else if (d >= 2) rec = p * (64'sd1 <<< (d - 2));
    else            rec = (p + (64'sd1 <<< (1 - d))) >>> (2 - d);
  endtask

  task automatic checkOldest();
    string vt = hBurst[2] ? "R11" : "R9";
    nChk++;
    if (outValid !== hv[2]) begin
      nBad++;
      $display("FAIL %s outValid act %0b exp %0b", vt, outValid, hv[2]);
    end
    if (hv[2]) begin
      nChk++;
      if (longint'(levelOut) != hl[2]) begin
        nBad++;
        $display("FAIL %s levelOut act %0d exp %0d", htL[2], levelOut, hl[2]);
      end
      nChk++;
      if (longint'(reconOut) != hr[2]) begin
        nBad++;
        $display("FAIL %s reconOut act %0d exp %0d", htR[2], reconOut, hr[2]);
      end
      heldL = hl[2];
      heldR = hr[2];
    end else begin
      // R9: idle slot keeps previous outputs
      nChk++;
      if (longint'(levelOut) != heldL || longint'(reconOut) != heldR) begin
        nBad++;
        $display("FAIL R9 hold act %0d/%0d exp %0d/%0d", levelOut, reconOut, heldL, heldR);
      end
    end
  endtask

  task automatic step(input bit v, input int coef, input int qp, input bit dc, input int pos);
    longint lev;
    longint rec;
    int qpc = (qp > 51) ? 51 : qp;
    @(negedge clk);
    checkOldest();
    for (int k = 2; k > 0; k--) begin
      hv[k] = hv[k-1]; hBurst[k] = hBurst[k-1];
      hl[k] = hl[k-1]; hr[k] = hr[k-1];
      htL[k] = htL[k-1]; htR[k] = htR[k-1];
    end
    hv[0] = v;
    hBurst[0] = v && prevV;
    prevV = v;
    if (v) begin
      model(coef, qp, dc, pos, lev, rec);
      hl[0] = lev;
      hr[0] = rec;
      if (coef == 0)    htL[0] = "R5";
      else if (qp > 51) htL[0] = "R1";
      else              htL[0] = dc ? "R3/R4" : "R2/R4";
      if (coef == 0)       htR[0] = "R5";
      else if (!dc)        htR[0] = "R6";
      else if (qpc >= 12)  htR[0] = "R7";
      else                 htR[0] = "R8";
    end
    inValid = v;
    coefIn  = 16'(coef);
    qpIn    = 6'(qp);
    isDcIn  = dc;
    posIn   = 4'(pos);
  endtask

  initial begin
    int coefs[12] = '{0, 1, -1, 2, -3, 37, -200, 1234, -4321, 32767, -32768, 9999};
    int n = 0;
    for (int k = 0; k < 3; k++) begin
      hv[k] = 1'b0; hBurst[k] = 1'b0; hl[k] = 0; hr[k] = 0;
      htL[k] = "R2"; htR[k] = "R6";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    nChk++;
    if (outValid !== 1'b0 || levelOut !== '0 || reconOut !== '0) begin
      nBad++;
      $display("FAIL R10 reset act %0b/%0d/%0d exp 0/0/0", outValid, levelOut, reconOut);
    end
    for (int qp = 0; qp < 56; qp++)
      for (int dc = 0; dc < 2; dc++)
        for (int pos = 0; pos < 16; pos++)
          for (int ci = 0; ci < 12; ci++) begin
            step(1'b1, coefs[ci], qp, dc[0], pos);
            n++;
            if (n % 13 == 0) step(1'b0, 0, 0, 1'b0, 0);
          end
    repeat (4) step(1'b0, 0, 0, 1'b0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R9 watchdog act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

endmodule